// File: doc/BRIEF.md
# TLP Header Trace Filter Gate

This block sits beside a PCIe core's header monitor and decides, one header at a time, whether a transaction layer packet header should be handed on to the trace recorder. A monitor presents each header as a one-cycle strobe with four attributes: the Requester ID, the index of the root port the packet passed through, a traffic class tag and a direction bit. The block compares these against a static configuration word and raises a one-cycle capture pulse on the following clock edge.

The configuration word packs four fields. The filter field selects headers either by a bitmask of root ports or by one exact Requester ID. The type field enables posted, non-posted and completion traffic. The direction code picks which inbound and outbound classes are eligible. The format code (4DW or 8DW record) changes how the direction code is read. Combinations that cannot be traced are reported on a configuration error output, and while that output is high nothing is captured.

Top module: `tlp_trace_gate`

## Requirements
- R1: `capture` is a registered decision. It goes high in the cycle right after a cycle with `hdrValid` high whose header passes every filter, it stays low after a cycle with `hdrValid` low, and it is low after reset.
- R2: With `cfg[19]` = 0 (Requester mode), a header can only pass if `hdrReqId` equals `cfg[15:0]` exactly. `cfg[18:16]` is reserved and has no effect.
- R3: With `cfg[19]` = 1 (port mode), a header can only pass if bit `hdrPort` of `cfg[15:0]` is set. Any number of mask bits may be set at once.
- R4: `hdrClass` encodes 0 = posted, 1 = non-posted, 2 = completion A, 3 = completion B. A header can only pass if its type bit is set: `cfg[20]` for posted, `cfg[21]` for non-posted, and `cfg[22]` for both completion subtypes. `cfg[27:23]` has no effect.
- R5: With format `cfg[35:32]` = 0 (4DW), the direction code `cfg[31:28]` means: 0 = every inbound class; 1 = every outbound class; 2 = every outbound class plus inbound posted, non-posted and completion B; 3 = every outbound class plus inbound completion A. `hdrOutbound` = 1 marks an outbound header.
- R6: With format 1 (8DW), direction code 1 = every outbound class, 2 = inbound posted, non-posted and completion B only, and 3 = inbound completion A only.
- R7: `configError` is high when the format code is above 1, when the direction code is above 3, or when the format is 8DW and the direction code is 0.
- R8: `configError` is high when the direction code enables any outbound class and more than one of `cfg[22:20]` is set. Several type bits with inbound-only directions are legal.
- R9: `configError` follows `cfg` combinationally in the same cycle. No header captures while it is high, even if every filter matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfg | input | 36 | Configuration word: filter [19:0], type [27:20], direction [31:28], format [35:32] |
| hdrValid | input | 1 | One-cycle strobe marking an observed header |
| hdrReqId | input | 16 | Requester ID of the header |
| hdrPort | input | PORT_IDX_W (4) | Root port index the header travelled through |
| hdrClass | input | 2 | Traffic class tag (see R4) |
| hdrOutbound | input | 1 | 1 = outbound header, 0 = inbound |
| capture | output | 1 | Registered capture decision |
| configError | output | 1 | Illegal configuration flag |

## Verification
The configuration error flag has no register in its path, so the bench reads it one time unit after driving a new configuration in the falling-edge half of the cycle. The capture decision passes through one flop. The bench drives each header on a falling edge, lets exactly one rising edge pass, and samples `capture` at the next falling edge. It then drops the strobe before the next header, so each pulse belongs to exactly one stimulus. Random configurations and headers are mixed with directed cases at the direction-table corners, and every result is compared with reference functions written from the requirements.

// File: rtl/tlp_trace_pkg.sv
package tlp_trace_pkg;
  localparam int CFG_W      = 36;
  localparam int FILT_VAL_W = 16;
  localparam int MODE_BIT   = 19;
  localparam int TYPE_LSB   = 20;
  localparam int TYPE_W     = 8;
  localparam int DIR_LSB    = 28;
  localparam int FMT_LSB    = 32;
  localparam int CODE_W     = 4;
  localparam int NUM_CLS    = 4;

  typedef enum logic [1:0] {
    CLS_POSTED  = 2'd0,
    CLS_NONPOST = 2'd1,
    CLS_CPL_A   = 2'd2,
    CLS_CPL_B   = 2'd3
  } hdrClass_e;

  // strobes from config control to match datapath
  typedef struct packed {
    logic                  portMode;
    logic [FILT_VAL_W-1:0] filtVal;
    logic [NUM_CLS-1:0]    inEn;
    logic [NUM_CLS-1:0]    outEn;
    logic                  block;
  } gateCtl_t;
endpackage

// File: rtl/trace_cfg_ctrl.sv
module trace_cfg_ctrl
  import tlp_trace_pkg::*;
(
  input  logic [CFG_W-1:0] cfgWord,
  output gateCtl_t         ctl,
  output logic             cfgBad
);
  logic [TYPE_W-1:0]  typeFld;
  logic [CODE_W-1:0]  dirFld;
  logic [CODE_W-1:0]  fmtFld;
  logic [NUM_CLS-1:0] inSet;
  logic               outAll;
  logic               codeBad;
  logic               multiType;
  logic [NUM_CLS-1:0] inEnV;
  logic [NUM_CLS-1:0] outEnV;
  logic               unusedBits;

  assign typeFld    = cfgWord[TYPE_LSB +: TYPE_W];
  assign dirFld     = cfgWord[DIR_LSB +: CODE_W];
  assign fmtFld     = cfgWord[FMT_LSB +: CODE_W];
  assign unusedBits = ^{cfgWord[MODE_BIT-1:FILT_VAL_W], typeFld[TYPE_W-1:3]};

  // direction table: inSet bit index is the class code
  always_comb begin
    inSet   = '0;
    outAll  = 1'b0;
    codeBad = 1'b0;
    unique case (fmtFld)
      4'd0: begin
        unique case (dirFld)
          4'd0: inSet = 4'b1111;
          4'd1: outAll = 1'b1;
          4'd2: begin outAll = 1'b1; inSet = 4'b1011; end
          4'd3: begin outAll = 1'b1; inSet = 4'b0100; end
          default: codeBad = 1'b1;
        endcase
      end
      4'd1: begin
        unique case (dirFld)
          4'd1: outAll = 1'b1;
          4'd2: inSet = 4'b1011;
          4'd3: inSet = 4'b0100;
          default: codeBad = 1'b1;
        endcase
      end
      default: codeBad = 1'b1;
    endcase
  end

  assign multiType = outAll && ($countones(typeFld[2:0]) > 1);
  assign cfgBad    = codeBad | multiType;

  // per-class enable: completions A and B share type bit 2
  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    localparam int TBIT = (c < 2) ? c : 2;
    assign inEnV[c]  = inSet[c] & typeFld[TBIT];
    assign outEnV[c] = outAll   & typeFld[TBIT];
  end

  always_comb begin
    ctl.portMode = cfgWord[MODE_BIT];
    ctl.filtVal  = cfgWord[FILT_VAL_W-1:0];
    ctl.inEn     = inEnV;
    ctl.outEn    = outEnV;
    ctl.block    = cfgBad;
  end
endmodule

// File: rtl/trace_match_dp.sv
module trace_match_dp
  import tlp_trace_pkg::*;
#(
  parameter int PORT_CNT   = 16,
  parameter int PORT_IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gateCtl_t              ctl,
  input  logic                  hdrValid,
  input  logic [FILT_VAL_W-1:0] hdrReqId,
  input  logic [PORT_IDX_W-1:0] hdrPort,
  input  logic [1:0]            hdrClass,
  input  logic                  hdrOutbound,
  output logic                  capture
);
  logic [PORT_CNT-1:0] portMask;
  logic                selHit;
  logic                classOk;
  logic                hitNext;

  assign portMask = ctl.filtVal[PORT_CNT-1:0];
  assign selHit   = ctl.portMode ? portMask[hdrPort] : (hdrReqId == ctl.filtVal);
  assign classOk  = hdrOutbound ? ctl.outEn[hdrClass] : ctl.inEn[hdrClass];
  assign hitNext  = hdrValid & ~ctl.block & selHit & classOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capture <= 1'b0;
    else       capture <= hitNext;
  end
endmodule

// File: rtl/tlp_trace_gate.sv
module tlp_trace_gate
  import tlp_trace_pkg::*;
#(
  parameter int PORT_CNT   = 16,
  localparam int PORT_IDX_W = $clog2(PORT_CNT)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CFG_W-1:0]      cfg,
  input  logic                  hdrValid,
  input  logic [FILT_VAL_W-1:0] hdrReqId,
  input  logic [PORT_IDX_W-1:0] hdrPort,
  input  logic [1:0]            hdrClass,
  input  logic                  hdrOutbound,
  output logic                  capture,
  output logic                  configError
);
  // PORT_CNT must not exceed the 16-bit filter mask
  gateCtl_t ctl;

  trace_cfg_ctrl u_ctrl (
    .cfgWord (cfg),
    .ctl     (ctl),
    .cfgBad  (configError)
  );

  trace_match_dp #(
    .PORT_CNT   (PORT_CNT),
    .PORT_IDX_W (PORT_IDX_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .hdrValid    (hdrValid),
    .hdrReqId    (hdrReqId),
    .hdrPort     (hdrPort),
    .hdrClass    (hdrClass),
    .hdrOutbound (hdrOutbound),
    .capture     (capture)
  );
endmodule

// File: rtl/tlp_trace_gate_checker.sv
module tlp_trace_gate_checker
  import tlp_trace_pkg::*;
#(
  parameter int PORT_IDX_W = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [CFG_W-1:0]      cfg,
  input logic                  hdrValid,
  input logic [FILT_VAL_W-1:0] hdrReqId,
  input logic [PORT_IDX_W-1:0] hdrPort,
  input logic [1:0]            hdrClass,
  input logic                  capture,
  input logic                  configError
);
  logic typeHit;
  always_comb begin
    case (hdrClass)
      2'd0:    typeHit = cfg[TYPE_LSB];
      2'd1:    typeHit = cfg[TYPE_LSB+1];
      default: typeHit = cfg[TYPE_LSB+2];
    endcase
  end

  assert_capture_after_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    capture |-> $past(hdrValid));

  assert_req_exact_R2: assert property (@(posedge clk) disable iff (!rstN)
    (capture && !$past(cfg[MODE_BIT])) |-> ($past(hdrReqId) == $past(cfg[FILT_VAL_W-1:0])));

  assert_port_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    (capture && $past(cfg[MODE_BIT])) |->
      ((($past(cfg[FILT_VAL_W-1:0]) >> $past(hdrPort)) & 16'd1) != 16'd0));

  assert_type_enabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    capture |-> $past(typeHit));

  assert_8dw_reserved_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfg[FMT_LSB +: CODE_W] == 4'd1 && cfg[DIR_LSB +: CODE_W] == 4'd0) |-> configError);

  assert_outbound_single_type_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfg[FMT_LSB +: CODE_W] == 4'd0 && cfg[DIR_LSB +: CODE_W] == 4'd1 &&
     $countones(cfg[TYPE_LSB +: 3]) > 1) |-> configError);

  assert_error_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    capture |-> !$past(configError));
endmodule

bind tlp_trace_gate tlp_trace_gate_checker #(.PORT_IDX_W(PORT_IDX_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfg         (cfg),
  .hdrValid    (hdrValid),
  .hdrReqId    (hdrReqId),
  .hdrPort     (hdrPort),
  .hdrClass    (hdrClass),
  .capture     (capture),
  .configError (configError)
);

// File: tb/test_tlp_trace_gate.sv
`timescale 1ns/1ps
module test_tlp_trace_gate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [35:0] cfg = '0;
  logic        hdrValid = 1'b0;
  logic [15:0] hdrReqId = '0;
  logic [3:0]  hdrPort = '0;
  logic [1:0]  hdrClass = '0;
  logic        hdrOutbound = 1'b0;
  logic        capture;
  logic        configError;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  tlp_trace_gate i_tlp_trace_gate (
    .clk(clk), .rstN(rstN), .cfg(cfg), .hdrValid(hdrValid), .hdrReqId(hdrReqId),
    .hdrPort(hdrPort), .hdrClass(hdrClass), .hdrOutbound(hdrOutbound),
    .capture(capture), .configError(configError)
  );

  function automatic logic [35:0] mkCfg(bit portMode, logic [15:0] val, logic [7:0] typ,
                                        logic [3:0] dir, logic [3:0] fmt, logic [2:0] resv);
    return {fmt, dir, typ, portMode, resv, val};
  endfunction

  function automatic bit refErr(logic [35:0] c);
    logic [3:0] fmt = c[35:32];
    logic [3:0] dir = c[31:28];
    bit outSel;
    if (fmt > 4'd1 || dir > 4'd3) return 1'b1;
    if (fmt == 4'd1 && dir == 4'd0) return 1'b1;
    outSel = (fmt == 4'd0) ? (dir != 4'd0) : (dir == 4'd1);
    if (outSel && ($countones(c[22:20]) > 1)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit refCap(logic [35:0] c, logic [15:0] id, logic [3:0] port,
                                logic [1:0] cls, bit outb);
    logic [3:0] fmt = c[35:32];
    logic [3:0] dir = c[31:28];
    bit sel, typOk, dirOk;
    if (refErr(c)) return 1'b0;
    sel   = c[19] ? c[port] : (id == c[15:0]);
    typOk = (cls == 2'd0) ? c[20] : (cls == 2'd1) ? c[21] : c[22];
    if (outb) dirOk = (fmt == 4'd0) ? (dir != 4'd0) : (dir == 4'd1);
    else if (fmt == 4'd0 && dir == 4'd0) dirOk = 1'b1;
    else if (dir == 4'd2) dirOk = (cls != 2'd2);
    else if (dir == 4'd3) dirOk = (cls == 2'd2);
    else dirOk = 1'b0;
    return sel && typOk && dirOk;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  // drive at falling edge, error flag read same cycle, capture one edge later
  task automatic runOne(string tag, logic [35:0] c, logic [15:0] id, logic [3:0] port,
                        logic [1:0] cls, bit outb, bit vld);
    @(negedge clk);
    cfg = c; hdrReqId = id; hdrPort = port; hdrClass = cls;
    hdrOutbound = outb; hdrValid = vld;
    #1;
    check({tag, " err"}, configError, refErr(c));
    @(negedge clk);
    check({tag, " cap"}, capture, vld & refCap(c, id, port, cls, outb));
    hdrValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [35:0] c;
    void'($urandom(32'h1C0FFEE));
    repeat (3) @(negedge clk);
    check("R1 reset", capture, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle", capture, 1'b0);

    // Requester mode
    c = mkCfg(0, 16'h0101, 8'h01, 4'd0, 4'd0, 3'd0);
    runOne("R2 exact id", c, 16'h0101, 4'd0, 2'd0, 0, 1);
    runOne("R2 near id", c, 16'h0100, 4'd0, 2'd0, 0, 1);
    runOne("R2 reserved bits", mkCfg(0, 16'h0101, 8'h01, 4'd0, 4'd0, 3'd7), 16'h0101, 4'd9, 2'd0, 0, 1);
    runOne("R1 no strobe", c, 16'h0101, 4'd0, 2'd0, 0, 0);

    // Port mode, mask bits 2 and 6
    c = mkCfg(1, 16'h0044, 8'h07, 4'd0, 4'd0, 3'd0);
    runOne("R3 port6", c, 16'h1234, 4'd6, 2'd1, 0, 1);
    runOne("R3 port4", c, 16'h0044, 4'd4, 2'd1, 0, 1);
    runOne("R3 port2", c, 16'h0000, 4'd2, 2'd3, 0, 1);

    // Types
    c = mkCfg(0, 16'h0A0A, 8'hFA, 4'd0, 4'd0, 3'd0);
    runOne("R4 P off", c, 16'h0A0A, 4'd0, 2'd0, 0, 1);
    runOne("R4 NP on", c, 16'h0A0A, 4'd0, 2'd1, 0, 1);
    c = mkCfg(0, 16'h0A0A, 8'h04, 4'd0, 4'd0, 3'd0);
    runOne("R4 CPL A", c, 16'h0A0A, 4'd0, 2'd2, 0, 1);
    runOne("R4 CPL B", c, 16'h0A0A, 4'd0, 2'd3, 0, 1);

    // 4DW direction table
    c = mkCfg(0, 16'h0005, 8'h04, 4'd2, 4'd0, 3'd0);
    runOne("R5 d2 in cplA", c, 16'h0005, 4'd0, 2'd2, 0, 1);
    runOne("R5 d2 in cplB", c, 16'h0005, 4'd0, 2'd3, 0, 1);
    runOne("R5 d2 out cpl", c, 16'h0005, 4'd0, 2'd2, 1, 1);
    c = mkCfg(0, 16'h0005, 8'h04, 4'd3, 4'd0, 3'd0);
    runOne("R5 d3 in cplA", c, 16'h0005, 4'd0, 2'd2, 0, 1);
    runOne("R5 d3 in cplB", c, 16'h0005, 4'd0, 2'd3, 0, 1);
    c = mkCfg(0, 16'h0005, 8'h02, 4'd1, 4'd0, 3'd0);
    runOne("R5 d1 out np", c, 16'h0005, 4'd0, 2'd1, 1, 1);
    runOne("R5 d1 in np", c, 16'h0005, 4'd0, 2'd1, 0, 1);
    runOne("R5 d0 out np", mkCfg(0, 16'h0005, 8'h02, 4'd0, 4'd0, 3'd0), 16'h0005, 4'd0, 2'd1, 1, 1);

    // 8DW direction table
    c = mkCfg(0, 16'h0777, 8'h01, 4'd2, 4'd1, 3'd0);
    runOne("R6 d2 out", c, 16'h0777, 4'd0, 2'd0, 1, 1);
    runOne("R6 d2 in", c, 16'h0777, 4'd0, 2'd0, 0, 1);
    c = mkCfg(0, 16'h0777, 8'h04, 4'd3, 4'd1, 3'd0);
    runOne("R6 d3 in cplA", c, 16'h0777, 4'd0, 2'd2, 0, 1);
    runOne("R6 d3 out cplA", c, 16'h0777, 4'd0, 2'd2, 1, 1);
    c = mkCfg(0, 16'h0777, 8'h01, 4'd1, 4'd1, 3'd0);
    runOne("R6 d1 out", c, 16'h0777, 4'd0, 2'd0, 1, 1);
    runOne("R6 d1 in", c, 16'h0777, 4'd0, 2'd0, 0, 1);

    // illegal codes
    runOne("R7 8dw d0", mkCfg(0, 16'h0777, 8'h07, 4'd0, 4'd1, 3'd0), 16'h0777, 4'd0, 2'd0, 0, 1);
    runOne("R7 dir5", mkCfg(0, 16'h0777, 8'h01, 4'd5, 4'd0, 3'd0), 16'h0777, 4'd0, 2'd0, 0, 1);
    runOne("R7 fmt3", mkCfg(0, 16'h0777, 8'h01, 4'd0, 4'd3, 3'd0), 16'h0777, 4'd0, 2'd0, 0, 1);
    runOne("R8 out two types", mkCfg(0, 16'h0777, 8'h03, 4'd1, 4'd0, 3'd0), 16'h0777, 4'd0, 2'd0, 1, 1);
    runOne("R8 in three types", mkCfg(0, 16'h0777, 8'h07, 4'd0, 4'd0, 3'd0), 16'h0777, 4'd0, 2'd1, 0, 1);
    runOne("R9 blocked match", mkCfg(1, 16'hFFFF, 8'h07, 4'd2, 4'd0, 3'd0), 16'h0000, 4'd3, 2'd0, 1, 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] val = 16'($urandom);
      logic [3:0] dir = ($urandom % 8 < 6) ? 4'($urandom % 4) : 4'($urandom);
      logic [3:0] fmt = ($urandom % 8 < 7) ? 4'($urandom % 2) : 4'($urandom);
      logic [7:0] typ = 8'($urandom);
      bit pm = 1'($urandom);
      logic [15:0] id = ($urandom % 2 == 0) ? val : 16'($urandom);
      c = mkCfg(pm, val, typ, dir, fmt, 3'($urandom));
      runOne("R1 R2 R3 R4 R5 R6 R7 R8 R9 random", c, id, 4'($urandom), 2'($urandom),
             1'($urandom), ($urandom % 8) != 0);
    end

    finishRun();
  end
endmodule